// File: doc/BRIEF.md
# Programmed-I/O Memory Write Request Formatter

This block turns one processor programmed-I/O store into a PCI Express memory-write request: a 128-bit header plus one 64-bit data word. Each request carries a physical address whose three lowest bits are treated as zero, an 8-bit byte mask covering the addressed 8-byte word, the store data, a requester ID, a tag and a control that forces 64-bit addressing. The mask's two nibbles become the first and last DW byte enables and set the payload length to one or two DWs. A two-DW write is always 8-byte aligned, so no write can cross a 64-byte boundary.

Requests enter on a valid/ready pair. The finished header and data leave on a second valid/ready pair through a one-entry holding register. A request with an empty byte mask is taken from the input but produces no header. Instead it raises a one-cycle error flag.

Top module: `pio_mwr_fmt`

## Requirements
- R1: After reset, `out_valid` and `err_flag` are 0 and `req_ready` is 1.
- R2: The header carries these fixed fields. Bit 127 is 0. Type is at [124:120] and is 00000, which means a memory request. Traffic class is at [118:116] and is 000. TD is at [111] and is 0. EP is at [110] and is 0. Attributes are at [109:108] and are 00. All other reserved bits in the upper two DWs are 0. The requester ID is at [95:80] and the tag is at [79:72].
- R3: The length is at [105:96], the last byte enable at [71:68] and the first byte enable at [67:64]. If mask[7:4] is zero, the length is 1, the first byte enable is mask[3:0] and the last byte enable is 0000. If only mask[3:0] is zero, the length is 1, the first byte enable is mask[7:4] and the last byte enable is 0000. Otherwise the length is 2, the first byte enable is mask[3:0] and the last byte enable is mask[7:4]. The nibbles need not be contiguous.
- R4: Address input bits [2:0] have no effect. The emitted low address word has bits [1:0] = 00. Its bit 2 is 1 only when a length-1 write uses mask[7:4], and it is 0 for every two-DW write.
- R5: The format field is at [126:125]. It is 11 (4-DW header with data) when address bits [63:32] are nonzero or `req_force64` is 1. Otherwise it is 10 (3-DW header with data). A 4-DW header puts address [63:32] in [63:32] and the low address word in [31:0]. A 3-DW header puts the low address word in [63:32] and zeros in [31:0].
- R6: A request with mask 00000000 is consumed when `req_valid` and `req_ready` are both 1. The cycle after, `err_flag` is 1 for one cycle and no header is presented.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_hdr` and `out_data` hold steady and `req_ready` is 0.
- R8: `out_data` equals the store data of the request that produced the header.
- R9: For every emitted header, address bits [5:2] plus the length never exceed 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Store request present |
| req_ready | output | 1 | Request taken on this edge when valid |
| req_addr | input | ADDR_W | Physical address; bits [2:0] ignored |
| req_mask | input | 8 | Byte mask over the 8-byte word |
| req_data | input | 64 | Store data |
| req_rid | input | 16 | Requester ID |
| req_tag | input | 8 | Transaction tag |
| req_force64 | input | 1 | Force 4-DW header |
| out_valid | output | 1 | Header and data present |
| out_ready | input | 1 | Downstream takes the request |
| out_hdr | output | 128 | Request header, DW0 in [127:96] |
| out_data | output | 64 | Payload |
| err_flag | output | 1 | One-cycle pulse for an empty byte mask |

## Verification
The assertions assume that the request fields stay steady during any cycle in which `req_valid` is high. The header checks also rely on `out_ready` changing only between clock edges. The stimulus drives every input only at the falling edge. It drops `req_valid` once each request has been taken, except in the backpressure case, which holds a second request steady on purpose. The sweep covers all 256 masks, including the empty one. It combines them with addresses whose low three bits are set and whose upper word is zero or nonzero.

// File: rtl/pio_mwr_pkg.sv
package pio_mwr_pkg;
   localparam logic [1:0] FMT_3DW_DATA = 2'b10;
   localparam logic [1:0] FMT_4DW_DATA = 2'b11;
   localparam logic [4:0] TYPE_MEMREQ  = 5'b00000;
   localparam int         HDR_W        = 128;
   localparam int         DATA_W       = 64;

   typedef struct packed {
      logic [9:0] len;
      logic [3:0] first_be;
      logic [3:0] last_be;
      logic       dw_hi;
      logic       empty;
   } be_info_t;
endpackage

// File: rtl/pio_be_decode.sv
module pio_be_decode
   import pio_mwr_pkg::*;
#(
   parameter int MASK_W = 8
)(
   input  logic [MASK_W-1:0] mask,
   output be_info_t          info
);
   localparam int NIB = MASK_W / 2;

   initial begin
      if (MASK_W != 8) $error("pio_be_decode: MASK_W must be 8");
   end

   logic [NIB-1:0] lo_nib, hi_nib;
   assign lo_nib = mask[NIB-1:0];
   assign hi_nib = mask[MASK_W-1:NIB];

   always_comb begin
      info       = '0;
      info.empty = (mask == '0);
      if (hi_nib == '0) begin
         info.len      = 10'd1;
         info.first_be = lo_nib;
      end else if (lo_nib == '0) begin
         info.len      = 10'd1;
         info.first_be = hi_nib;
         info.dw_hi    = 1'b1;
      end else begin
         info.len      = 10'd2;
         info.first_be = lo_nib;
         info.last_be  = hi_nib;
      end
   end
endmodule

// File: rtl/pio_hdr_build.sv
module pio_hdr_build
   import pio_mwr_pkg::*;
#(
   parameter int ADDR_W = 64
)(
   input  logic [ADDR_W-1:0] addr,
   input  be_info_t          info,
   input  logic [15:0]       rid,
   input  logic [7:0]        tag,
   input  logic              force64,
   output logic [HDR_W-1:0]  hdr
);
   initial begin
      if (ADDR_W < 32 || ADDR_W > 64) $error("pio_hdr_build: ADDR_W out of 32..64");
   end

   logic [31:0] upper_w;
   logic        wide;

   generate
      if (ADDR_W > 32) begin : g_wide_addr
         assign upper_w = 32'(addr[ADDR_W-1:32]);
         assign wide    = force64 | (|addr[ADDR_W-1:32]);
      end else begin : g_narrow_addr
         assign upper_w = 32'd0;
         assign wide    = force64;
      end
   endgenerate

   logic [31:0] low_w, dw0, dw1;
   assign low_w = {addr[31:3], info.dw_hi, 2'b00};

   assign dw0 = {1'b0, (wide ? FMT_4DW_DATA : FMT_3DW_DATA), TYPE_MEMREQ,
                 1'b0, 3'b000, 4'b0000, 1'b0, 1'b0, 2'b00, 2'b00, info.len};
   assign dw1 = {rid, tag, info.last_be, info.first_be};

   assign hdr = wide ? {dw0, dw1, upper_w, low_w}
                     : {dw0, dw1, low_w, 32'd0};
endmodule

// File: rtl/pio_out_stage.sv
module pio_out_stage #(
   parameter int W = 192
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   output logic         in_ready,
   output logic         out_valid,
   output logic [W-1:0] out_data,
   input  logic         out_ready
);
   assign in_ready = !out_valid || out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (in_ready) begin
         out_valid <= in_valid;
         if (in_valid) out_data <= in_data;
      end
   end

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7
endmodule

// File: rtl/pio_mwr_fmt.sv
module pio_mwr_fmt
   import pio_mwr_pkg::*;
#(
   parameter int ADDR_W = 64
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [7:0]        req_mask,
   input  logic [63:0]       req_data,
   input  logic [15:0]       req_rid,
   input  logic [7:0]        req_tag,
   input  logic              req_force64,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [127:0]      out_hdr,
   output logic [63:0]       out_data,
   output logic              err_flag
);
   localparam int PAY_W = HDR_W + DATA_W;

   be_info_t         info;
   logic [HDR_W-1:0] hdr_c;
   logic [PAY_W-1:0] pay_q;

   pio_be_decode #(.MASK_W(8)) u_dec (.mask(req_mask), .info(info));

   pio_hdr_build #(.ADDR_W(ADDR_W)) u_hdr (
      .addr(req_addr), .info(info), .rid(req_rid), .tag(req_tag),
      .force64(req_force64), .hdr(hdr_c));

   pio_out_stage #(.W(PAY_W)) u_out (
      .clk(clk), .rst_n(rst_n),
      .in_valid(req_valid && !info.empty), .in_data({hdr_c, req_data}),
      .in_ready(req_ready),
      .out_valid(out_valid), .out_data(pay_q), .out_ready(out_ready));

   assign out_hdr  = pay_q[PAY_W-1:DATA_W];
   assign out_data = pay_q[DATA_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) err_flag <= 1'b0;
      else        err_flag <= req_valid && req_ready && info.empty;
   end

   logic [31:0] low_word;
   logic [9:0]  hdr_len;
   assign low_word = out_hdr[125] ? out_hdr[31:0] : out_hdr[63:32];
   assign hdr_len  = out_hdr[105:96];

   AST_BE_RULES: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((hdr_len == 10'd1 && out_hdr[67:64] != 4'd0 && out_hdr[71:68] == 4'd0) ||
                     (hdr_len == 10'd2 && out_hdr[67:64] != 4'd0 && out_hdr[71:68] != 4'd0))); // R3
   AST_LOW_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (low_word[1:0] == 2'b00 && !(hdr_len == 10'd2 && low_word[2]))); // R4
   AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((10'(low_word[5:2]) + hdr_len) <= 10'd16)); // R9
   AST_EMPTY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_mask == 8'd0) |=> (err_flag && !out_valid)); // R6
   AST_STALL_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !req_ready); // R7
endmodule

// File: tb/pio_mwr_fmt_bench.sv
module pio_mwr_fmt_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0, req_force64 = 1'b0, out_ready = 1'b1;
   logic [63:0]  req_addr = '0, req_data = '0;
   logic [7:0]   req_mask = '0, req_tag = '0;
   logic [15:0]  req_rid = '0;
   logic         req_ready, out_valid, err_flag;
   logic [127:0] out_hdr;
   logic [63:0]  out_data;

   int vectors = 0, fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pio_mwr_fmt u_pio_mwr_fmt (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_mask(req_mask), .req_data(req_data),
      .req_rid(req_rid), .req_tag(req_tag), .req_force64(req_force64),
      .out_valid(out_valid), .out_ready(out_ready), .out_hdr(out_hdr),
      .out_data(out_data), .err_flag(err_flag));

   task automatic chk(input string what, input logic [127:0] got, input logic [127:0] exp);
      vectors++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", what, got, exp);
      end
   endtask

   function automatic logic [127:0] exp_hdr(input logic [63:0] a, input logic [7:0] m,
                                            input logic [15:0] rid, input logic [7:0] tg,
                                            input logic f64);
      logic [9:0]  ln;
      logic [3:0]  fb, lb;
      logic        hi;
      logic        four;
      logic [31:0] lw;
      ln = (m[7:4] != 0 && m[3:0] != 0) ? 10'd2 : 10'd1;
      hi = (m[3:0] == 0);
      fb = hi ? m[7:4] : m[3:0];
      lb = (ln == 10'd2) ? m[7:4] : 4'd0;
      four = f64 || (a[63:32] != 0);
      lw = (a[31:0] & 32'hFFFF_FFF8) | (hi ? 32'd4 : 32'd0);
      exp_hdr[127:96] = {1'b0, four ? 2'b11 : 2'b10, 5'd0, 14'd0, ln};
      exp_hdr[95:64]  = {rid, tg, lb, fb};
      exp_hdr[63:0]   = four ? {a[63:32], lw} : {lw, 32'd0};
   endfunction

   task automatic drive(input logic [63:0] a, input logic [7:0] m, input logic [63:0] d,
                        input logic [15:0] rid, input logic [7:0] tg, input logic f64);
      req_addr = a; req_mask = m; req_data = d; req_rid = rid; req_tag = tg;
      req_force64 = f64; req_valid = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      logic [63:0] addrs [4];
      logic [127:0] eh;
      addrs[0] = 64'h0000_0000_1234_5677;
      addrs[1] = 64'h0000_0001_0000_0043;
      addrs[2] = 64'hFFFF_FFFF_FFFF_FFFF;
      addrs[3] = 64'h0000_0000_FFFF_FFC4;

      repeat (3) @(negedge clk);
      chk("R1 out_valid at reset", 128'(out_valid), 128'd0);
      chk("R1 err_flag at reset", 128'(err_flag), 128'd0);
      chk("R1 req_ready at reset", 128'(req_ready), 128'd1);
      rst_n = 1'b1;
      @(negedge clk);

      for (int ai = 0; ai < 4; ai++) begin
         for (int f = 0; f < 2; f++) begin
            for (int mi = 0; mi < 256; mi++) begin
               logic [63:0] d;
               d = {8'(mi), 8'(ai), 48'h5A5A_C3C3_0F0F} ^ {16'(f), 48'd0};
               drive(addrs[ai], 8'(mi), d, 16'(mi * 7 + ai), 8'(mi ^ 8'hA5), f[0]);
               @(negedge clk);
               req_valid = 1'b0;
               if (mi == 0) begin
                  chk("R6 empty mask no header", 128'(out_valid), 128'd0);
                  chk("R6 empty mask err pulse", 128'(err_flag), 128'd1);
               end else begin
                  eh = exp_hdr(addrs[ai], 8'(mi), 16'(mi * 7 + ai), 8'(mi ^ 8'hA5), f[0]);
                  chk("R2 out_valid", 128'(out_valid), 128'd1);
                  chk("R2 fixed fields, rid, tag", 128'({out_hdr[127], out_hdr[124:106], out_hdr[95:72]}),
                      128'({eh[127], eh[124:106], eh[95:72]}));
                  chk("R3 length and byte enables", 128'({out_hdr[105:96], out_hdr[71:64]}),
                      128'({eh[105:96], eh[71:64]}));
                  chk("R5 format and address words", 128'({out_hdr[126:125], out_hdr[63:0]}),
                      128'({eh[126:125], eh[63:0]}));
                  chk("R4 low address bits", 128'(out_hdr[125] ? out_hdr[2:0] : out_hdr[34:32]),
                      128'(eh[125] ? eh[2:0] : eh[34:32]));
                  chk("R9 boundary", 128'((out_hdr[125] ? out_hdr[5:2] : out_hdr[37:34]) + out_hdr[99:96] <= 16),
                      128'd1);
                  chk("R8 data", 128'(out_data), 128'(d));
                  chk("R6 no err for nonempty", 128'(err_flag), 128'd0);
               end
               @(negedge clk);
               if (mi == 0) chk("R6 err one cycle", 128'(err_flag), 128'd0);
            end
         end
      end

      out_ready = 1'b0;
      drive(64'h0000_0000_0000_1008, 8'h0F, 64'h1111_2222_3333_4444, 16'hBEEF, 8'h11, 1'b0);
      @(negedge clk);
      drive(64'h0000_0002_0000_2010, 8'hFF, 64'h9999_8888_7777_6666, 16'hCAFE, 8'h22, 1'b0);
      chk("R7 ready low while stalled", 128'(req_ready), 128'd0);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R7 header held", out_hdr, exp_hdr(64'h1008, 8'h0F, 16'hBEEF, 8'h11, 1'b0));
         chk("R7 data held", 128'(out_data), 128'(64'h1111_2222_3333_4444));
      end
      out_ready = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R7 next request after release", out_hdr,
          exp_hdr(64'h0000_0002_0000_2010, 8'hFF, 16'hCAFE, 8'h22, 1'b0));
      chk("R8 data after release", 128'(out_data), 128'(64'h9999_8888_7777_6666));
      @(negedge clk);
      @(negedge clk);
      chk("R7 drained", 128'(out_valid), 128'd0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule